// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM

This block is a clocked, synthesizable model of a flow-through synchronous SRAM. A command and an address are sampled on a rising clock edge. Read data is presented combinationally in the cycle that follows the sampling edge. Write data arrives one clock later than the write command. Because write data lags its command by the same one cycle that read data lags a read, a shared data bus can carry reads and writes in any mix without idle turnaround cycles.

The array is parameterized as `DEPTH` words of `LANES` byte lanes of `LANE_W` bits each; the default is 256 x 36 in four 9-bit lanes. A separate burst sequencer produces the continuation addresses of a four-beat burst, in linear or interleaved order. A tri-state pad is not modelled. The block presents a data-out bus together with a flag that says when the pad would drive it.

The controller is a three-state machine:
- `ST_DESEL`: nothing selected, bus undriven.
- `ST_READ`: a read beat is being presented.
- `ST_WRITE`: a write beat whose data is expected at the next enabled edge.

Its transitions are:
- LOAD_READ: burst_go low, all selects active, is_read high.
- LOAD_WRITE: as LOAD_READ, but with is_read low.
- LOAD_DESEL: burst_go low, with any select inactive.
- CONTINUE: burst_go high. The machine stays in its state and the burst address steps.
- STALL: hold high. The state and all registers freeze.

Top module: `latewrite_sram`

## Requirements
- R1: After reset the block is deselected: drive is 0 and rdata is 0.
- R2: An enabled edge with burst_go=0 and any select inactive (sel_a_n=1, sel_b=0 or sel_c_n=1) deselects the block. In the following cycle drive=0 and rdata=0, and no new write is started.
- R3: An enabled edge with burst_go=0, all selects active and is_read=0 starts a write to addr. At the next enabled edge, each lane i (bits 9i+8..9i) whose bwe_n[i]=0 takes that lane of wdata. All other lanes keep their contents.
- R4: A write beat with bwe_n=4'b1111 is an abort. No word of the array changes.
- R5: A read loaded at the edge that delivers a write's data, to the same address, returns the freshly written lanes merged with the old lanes. No idle cycle is needed between any mix of reads and writes.
- R6: An enabled edge with burst_go=1 continues the current burst type. addr, the selects and is_read are ignored. The address low two bits become base+n mod 4 when linear=1, or base XOR n when linear=0. Here n counts continue beats since the load, and the high bits are kept.
- R7: burst_go=1 while deselected keeps the block deselected.
- R8: While hold=1 no state changes and no write happens. rdata and drive keep their values: driven during a read, undriven during a write.
- R9: During a write beat drive=0 and rdata=0, even with out_en_n=0.
- R10: A read beat drives the data (drive=1, rdata = addressed word) only while out_en_n=0. out_en_n acts combinationally, without waiting for a clock. A read with out_en_n=1 is a dummy read with drive=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| hold | input | 1 | 1 masks the clock edge (stall) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_go | input | 1 | 1 continues the burst, 0 loads a new command |
| is_read | input | 1 | 1 read, 0 write, sampled on load |
| bwe_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address, sampled on load |
| wdata | input | LANES*LANE_W | Write data, sampled one enabled edge after its command |
| rdata | output | LANES*LANE_W | Read data, zero when not a read beat |
| drive | output | 1 | 1 when the pad would drive rdata |

## Verification
The hardest case to reach is a write whose data capture edge is separated from its command by a stall. In that case the pending write must survive masked edges while the data bus carries garbage. The same capture edge must then also load a read of the same address, and that read must see the merged lanes. The stimulus places a partial-lane write, then hold=1 cycles with deliberately wrong wdata, then an enabled edge that carries the true data and loads the read of that address. A behavioural reference array, compared on every clock, predicts the merged word.

// File: rtl/lws_pkg.sv
`timescale 1ns/1ps
package lws_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } lws_state_e;
endpackage

// File: rtl/lws_ctrl.sv
`timescale 1ns/1ps
module lws_ctrl
    import lws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       burst_go,
    input  logic       sel_ok,
    input  logic       is_read,
    output lws_state_e state,
    output logic       load,
    output logic       step,
    output logic       commit
);
    lws_state_e nxt;
    lws_state_e ld_kind;

    always_comb begin
        if (!sel_ok)      ld_kind = ST_DESEL;
        else if (is_read) ld_kind = ST_READ;
        else              ld_kind = ST_WRITE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESEL;
        else        state <= nxt;
    end

    // next state: load replaces the state, continue keeps it, stall freezes it
    always_comb begin
        nxt = state;
        unique case (state)
            ST_DESEL: if (en && !burst_go) nxt = ld_kind;
            ST_READ:  if (en && !burst_go) nxt = ld_kind;
            ST_WRITE: if (en && !burst_go) nxt = ld_kind;
            default:  nxt = ST_DESEL;
        endcase
    end

    // outputs
    always_comb begin
        load   = en && !burst_go && sel_ok;
        step   = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_DESEL: step = 1'b0;
            ST_READ:  step = en && burst_go;
            ST_WRITE: begin
                step   = en && burst_go;
                commit = en;
            end
            default: begin
                step   = 1'b0;
                commit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lws_burst.sv
`timescale 1ns/1ps
module lws_burst #(
    parameter int ADDR_W = 8,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [SEQ_W-1:0]  cnt_q;
    logic [SEQ_W-1:0]  lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= ld_addr;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (linear) lo = base_q[SEQ_W-1:0] + cnt_q;
        else        lo = base_q[SEQ_W-1:0] ^ cnt_q;
    end

    assign cur_addr = {base_q[ADDR_W-1:SEQ_W], lo};
endmodule

// File: rtl/lws_array.sv
`timescale 1ns/1ps
module lws_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/latewrite_sram.sv
`timescale 1ns/1ps
module latewrite_sram
    import lws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int SEQ_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    burst_go,
    input  logic                    is_read,
    input  logic [LANES-1:0]        bwe_n,
    input  logic                    out_en_n,
    input  logic                    linear,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive
);
    localparam int DW = LANES * LANE_W;

    lws_state_e        cur_state;
    logic              en, sel_ok, load, step, commit;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_q;
    logic [DW-1:0]     arr_rd;

    assign en     = !hold;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    lws_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .burst_go (burst_go),
        .sel_ok   (sel_ok),
        .is_read  (is_read),
        .state    (cur_state),
        .load     (load),
        .step     (step),
        .commit   (commit)
    );

    lws_burst #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .linear   (linear),
        .ld_addr  (addr),
        .cur_addr (cur_addr)
    );

    // delay register for the lane enables of the pending write beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            lane_q <= '0;
        else if (load || step) lane_q <= ~bwe_n;
    end

    lws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (commit),
        .lane_we (lane_q),
        .addr    (cur_addr),
        .wdata   (wdata),
        .rdata   (arr_rd)
    );

    assign rdata = (cur_state == ST_READ) ? arr_rd : '0;
    assign drive = (cur_state == ST_READ) && !out_en_n;
endmodule

// File: rtl/latewrite_sram_chk.sv
`timescale 1ns/1ps
module latewrite_sram_chk
    import lws_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          burst_go,
    input logic          is_read,
    input logic [DW-1:0] rdata,
    input logic          drive,
    input lws_state_e    cur_state
);
    logic sel;
    assign sel = !sel_a_n && sel_b && !sel_c_n;

    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !burst_go && !sel) |=> (!drive && rdata == '0));

    a_r9_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !burst_go && sel && !is_read) |=> !drive);

    a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(cur_state) && $stable(rdata)));

    a_r7_stay_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_go && cur_state == ST_DESEL) |=> cur_state == ST_DESEL);

    a_r6_keep_type: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_go) |=> cur_state == $past(cur_state));
endmodule

bind latewrite_sram latewrite_sram_chk #(.DW(LANES*LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .burst_go  (burst_go),
    .is_read   (is_read),
    .rdata     (rdata),
    .drive     (drive),
    .cur_state (cur_state)
);

// File: tb/tb_latewrite_sram.sv
`timescale 1ns/1ps
module tb_latewrite_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        burst_go = 1'b0, is_read = 1'b1, out_en_n = 1'b0, linear = 1'b1;
    logic [3:0]  bwe_n = 4'hF;
    logic [7:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        drive;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [35:0] ref_mem [256];
    int          mtype = 0;              // 0 deselected, 1 read, 2 write
    logic [7:0]  maddr = '0;
    logic [3:0]  mbw = 4'hF;
    logic [1:0]  mbase = '0;
    int          mcnt = 0;

    always #10 clk = ~clk;

    latewrite_sram dut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_go(burst_go), .is_read(is_read), .bwe_n(bwe_n),
        .out_en_n(out_en_n), .linear(linear), .addr(addr), .wdata(wdata),
        .rdata(rdata), .drive(drive)
    );

    function automatic logic [35:0] pat(input int a, input int s);
        return {4'(s), 8'(a), 8'(~a), 16'(a * 97 + s * 13)};
    endfunction

    task automatic check1(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic        e_drv;
        logic [35:0] e_dat;
        e_drv = (mtype == 1) && !out_en_n;
        e_dat = (mtype == 1) ? ref_mem[maddr] : 36'd0;
        check1({tag, " drive"}, {35'd0, drive}, {35'd0, e_drv});
        check1({tag, " rdata"}, rdata, e_dat);
    endtask

    // inputs are already applied; one clock, model update, compare mid-high
    task automatic tick(input string tag);
        @(posedge clk);
        if (!hold) begin
            if (mtype == 2)
                for (int i = 0; i < 4; i++)
                    if (!mbw[i]) ref_mem[maddr][i*9 +: 9] = wdata[i*9 +: 9];
            if (!burst_go) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    mtype = is_read ? 1 : 2;
                    maddr = addr; mbase = addr[1:0]; mcnt = 0; mbw = bwe_n;
                end else mtype = 0;
            end else if (mtype != 0) begin
                mcnt = (mcnt + 1) % 4;
                maddr[1:0] = linear ? 2'(int'(mbase) + mcnt) : (mbase ^ 2'(mcnt));
                mbw = bwe_n;
            end
        end
        #5;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [35:0] d);
        hold = 0; burst_go = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        is_read = 1; addr = a; wdata = d; bwe_n = 4'hF;
        tick(tag);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [3:0] bw,
                      input logic [35:0] d);
        hold = 0; burst_go = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        is_read = 0; addr = a; wdata = d; bwe_n = bw;
        tick(tag);
    endtask

    task automatic cont(input string tag, input logic [3:0] bw, input logic [35:0] d);
        hold = 0; burst_go = 1; addr = 8'hA5; is_read = ~is_read;
        sel_a_n = 1; sel_b = 0; sel_c_n = 1;
        bwe_n = bw; wdata = d;
        tick(tag);
    endtask

    task automatic ds(input string tag, input int which, input logic [35:0] d);
        hold = 0; burst_go = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        if (which == 0) sel_a_n = 1;
        else if (which == 1) sel_b = 0;
        else sel_c_n = 1;
        is_read = 0; bwe_n = 4'h0; addr = 8'h77; wdata = d;
        tick(tag);
    endtask

    task automatic stall(input string tag);
        hold = 1; burst_go = ~burst_go; addr = ~addr; is_read = ~is_read;
        bwe_n = 4'h0; wdata = 36'hBAD_BAD_BAD;
        tick(tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        check1("R1 reset drive", {35'd0, drive}, 36'd0);
        check1("R1 reset rdata", rdata, 36'd0);
        ds("R1 idle", 0, 36'd0);

        // R3: fill the whole array with back-to-back full writes
        wr("R3 fill", 8'd0, 4'h0, 36'd0);
        for (int a = 1; a < 256; a++) wr("R3 fill", 8'(a), 4'h0, pat(a - 1, 1));
        ds("R3 fill end", 1, pat(255, 1));

        // R1: plain reads
        rd("R1 read", 8'd3, 36'd0);
        rd("R1 read", 8'd200, 36'd0);
        rd("R1 read", 8'd255, 36'd0);

        // R3/R5: partial-lane write then read of the same address with no gap
        wr("R3 partial", 8'd5, 4'b1010, 36'd0);
        rd("R5 merge", 8'd5, 36'h1_2345_6789);
        // R4: write abort
        wr("R4 abort", 8'd6, 4'hF, 36'd0);
        rd("R4 unchanged", 8'd6, 36'hF_FFFF_FFFF);
        // R5: alternating writes and reads, different and same addresses
        wr("R5 mix", 8'd10, 4'h0, 36'd0);
        rd("R5 mix", 8'd11, pat(10, 7));
        wr("R5 mix", 8'd11, 4'b0110, 36'd0);
        wr("R5 mix", 8'd12, 4'h0, pat(11, 7));
        rd("R5 mix", 8'd11, pat(12, 7));
        rd("R5 mix", 8'd12, 36'd0);

        // R6: bursts, linear and interleaved, with garbage on ignored inputs
        linear = 1;
        rd("R6 lin", 8'h12, 36'd0);
        for (int i = 0; i < 4; i++) cont("R6 lin cont", 4'hF, 36'd0);
        linear = 0;
        rd("R6 ilv", 8'h23, 36'd0);
        for (int i = 0; i < 3; i++) cont("R6 ilv cont", 4'hF, 36'd0);
        wr("R6 wburst", 8'h31, 4'h0, 36'd0);
        cont("R6 wburst", 4'b1100, pat(49, 3));
        cont("R6 wburst", 4'h0, pat(50, 3));
        cont("R6 wburst", 4'hF, pat(51, 3));
        rd("R6 wburst rb", 8'h30, pat(52, 3));
        for (int i = 0; i < 3; i++) cont("R6 wburst rb", 4'hF, 36'd0);
        linear = 1;

        // R2/R7: deselect through each select, then continue-deselect
        rd("R2 pre", 8'd40, 36'd0);
        ds("R2 desel a", 0, 36'd0);
        cont("R7 cont desel", 4'h0, 36'hABC);
        rd("R2 pre", 8'd41, 36'd0);
        ds("R2 desel b", 1, 36'd0);
        wr("R2 pre", 8'd42, 4'h0, 36'd0);
        ds("R2 desel c", 2, pat(42, 9));
        cont("R7 cont desel", 4'h0, 36'h123);
        cont("R7 cont desel", 4'h0, 36'h456);
        rd("R2 check", 8'd42, 36'd0);

        // R8: stall during a read and during a write
        rd("R8 read", 8'd60, 36'd0);
        stall("R8 stall read");
        stall("R8 stall read");
        cont("R8 after", 4'hF, 36'd0);
        wr("R8 write", 8'd70, 4'b0101, 36'd0);
        stall("R8 stall write");
        stall("R8 stall write");
        rd("R8 merge", 8'd70, 36'h9_8765_4321);

        // R9: write beats are undriven with out_en_n low
        out_en_n = 0;
        wr("R9 write", 8'd80, 4'h0, 36'd0);
        wr("R9 write", 8'd81, 4'h0, pat(80, 5));
        ds("R9 end", 0, pat(81, 5));

        // R10: dummy read and asynchronous output enable
        out_en_n = 1;
        rd("R10 dummy", 8'd80, 36'd0);
        out_en_n = 0;
        rd("R10 read", 8'd81, 36'd0);
        out_en_n = 1; #1;
        check1("R10 async off", {35'd0, drive}, 36'd0);
        out_en_n = 0; #1;
        check1("R10 async on", {35'd0, drive}, 36'd1);
        rd("R10 read", 8'd80, 36'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule